// File: doc/BRIEF.md
# Offset-calibrating ADC sample to Q-format converter

This block sits between a 12-bit single-supply converter and a 16-bit signed datapath. Each incoming code is unsigned and centred on mid-scale. The block turns it into a two's-complement fraction that fills the top of the 16-bit word. It has two ways to remove the zero point. The first is a fixed mid-scale conversion, which only flips the sign bit. The second subtracts a zero offset that the block measures itself: after a calibration request it averages a block of samples taken with no input applied.

After alignment, an optional signed gain rescales the fraction into any other Q format. The output is the high half of the 32-bit product. Samples arrive on a strobe with no back-pressure. Results leave on a strobe exactly two clock cycles later. While a calibration is collecting samples, no results are produced.

Top module: `adc_qconv`

## Requirements
- R1: After reset, result_valid_o, cal_done_o and result_o are 0, and the stored offset is 2048. Calibrated mode therefore maps code 4095 to 0x7FF0 until the first calibration ends.
- R2: With cal_mode_i=0 (mid-scale mode), the sample MSB is inverted, the new sign is extended, and the value is shifted left by 4. Codes 0, 2048 and 4095 map to 0x8000, 0x0000 and 0x7FF0, and the low 4 bits are always 0. Any stored offset has no effect in this mode.
- R3: A cal_start_i pulse while idle starts a calibration. The next 4096 strobed samples are summed in a 24-bit accumulator. Sum>>12 (truncating) becomes the offset. cal_done_o is high for exactly one cycle, right after the clock edge that takes the 4096th sample.
- R4: While a calibration is running, no result_valid_o is produced, and a further cal_start_i has no effect on when the calibration ends or on the offset it stores.
- R5: With cal_mode_i=1, the result is (sample - offset) shifted left by 4, as a two's-complement value.
- R6: A calibrated result above 32767 clamps to 0x7FFF. A result below -32768 clamps to 0x8000.
- R7: With gain_bypass_i=0, result_o is bits [31:16] of the signed product of the aligned word and gain_i. gain_i is read as two's complement, so 28672 means 0.875.
- R8: With gain_bypass_i=1, result_o equals the aligned 16-bit word, whatever the value of gain_i.
- R9: Each accepted strobe gives exactly one result_valid_o pulse two clock edges later. Back-to-back strobes give back-to-back results.
- R10: gain_i and gain_bypass_i are captured only on edges where neither the input strobe nor the internal aligned-sample strobe is high. A change during a burst of strobes affects only samples sent after the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Sample strobe |
| sample_i | input | 12 | Unsigned converter code |
| cal_mode_i | input | 1 | 1: subtract stored offset, 0: fixed mid-scale |
| cal_start_i | input | 1 | Start offset calibration |
| gain_bypass_i | input | 1 | 1: skip the gain multiply |
| gain_i | input | 16 | Signed gain, Q15 |
| cal_done_o | output | 1 | One-cycle pulse when a new offset is stored |
| result_valid_o | output | 1 | Result strobe |
| result_o | output | 16 | Signed result word |

## Verification
A wrong stored offset does not show up on its own. It becomes a constant bias on every calibrated result, two cycles after the first strobe that follows calibration. The bench therefore converts codes at and around the expected offset, and at the extremes where saturation starts. A miscounting calibration counter moves the cal_done_o pulse away from the 4096th sample, so the bench checks that edge exactly. A gain register captured at the wrong moment corrupts only the tail of a burst, so the bench changes the gain during a burst and compares every result of that burst.

// File: rtl/adc_qconv_pkg.sv
package adc_qconv_pkg;
  localparam int unsigned ADC_W_DEF    = 12;
  localparam int unsigned OUT_W_DEF    = 16;
  localparam int unsigned GAIN_W_DEF   = 16;
  localparam int unsigned CAL_LOG2_DEF = 12;

  typedef enum logic {
    CONV_MIDSCALE   = 1'b0,
    CONV_CALIBRATED = 1'b1
  } conv_mode_e;
endpackage

// File: rtl/adc_offset_cal.sv
module adc_offset_cal
  import adc_qconv_pkg::*;
#(
  parameter int unsigned ADC_W    = ADC_W_DEF,
  parameter int unsigned CAL_LOG2 = CAL_LOG2_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cal_start_i,
  input  logic             sample_valid_i,
  input  logic [ADC_W-1:0] sample_i,
  output logic             busy_o,
  output logic [ADC_W-1:0] offset_o,
  output logic             cal_done_o
);
  localparam int unsigned ACC_W = ADC_W + CAL_LOG2;
  localparam logic [ADC_W-1:0] MID_CODE = ADC_W'(1) << (ADC_W - 1);

  logic [ACC_W-1:0]    acc_q;
  logic [ACC_W-1:0]    sum_next;
  logic [CAL_LOG2-1:0] cnt_q;
  logic                last_sample;

  assign sum_next    = acc_q + ACC_W'(sample_i);
  assign last_sample = busy_o && sample_valid_i && (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o     <= 1'b0;
      acc_q      <= '0;
      cnt_q      <= '0;
      offset_o   <= MID_CODE;
      cal_done_o <= 1'b0;
    end else begin
      cal_done_o <= 1'b0;
      if (!busy_o) begin
        acc_q <= '0;
        cnt_q <= '0;
        if (cal_start_i) busy_o <= 1'b1;
      end else if (sample_valid_i) begin
        acc_q <= sum_next;
        cnt_q <= cnt_q + 1'b1;
        if (last_sample) begin
          offset_o   <= ADC_W'(sum_next >> CAL_LOG2);
          busy_o     <= 1'b0;
          cal_done_o <= 1'b1;
        end
      end
    end
  end

  p_done_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_done_o |=> !cal_done_o);
  p_done_ends_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_done_o |-> (!busy_o && $past(busy_o)));
  p_restart_ignored_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !sample_valid_i) |=> busy_o);
endmodule

// File: rtl/adc_q15_align.sv
module adc_q15_align
  import adc_qconv_pkg::*;
#(
  parameter int unsigned ADC_W = ADC_W_DEF,
  parameter int unsigned OUT_W = OUT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  conv_mode_e       mode_i,
  input  logic [ADC_W-1:0] sample_i,
  input  logic [ADC_W-1:0] offset_i,
  output logic             valid_o,
  output logic [OUT_W-1:0] q_o
);
  localparam int unsigned SH     = OUT_W - ADC_W;
  localparam int unsigned DIFF_W = ADC_W + 1;
  localparam int unsigned WIDE_W = DIFF_W + SH;
  localparam int unsigned TOP_W  = WIDE_W - OUT_W + 1;
  localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_MAX = {1'b1, {(OUT_W-1){1'b0}}};

  logic [OUT_W-1:0]  mid_word;
  logic [DIFF_W-1:0] diff;
  logic [WIDE_W-1:0] wide;
  logic [TOP_W-1:0]  top_bits;
  logic              in_range;
  logic [OUT_W-1:0]  cal_word;

  // flipping the MSB of an offset-binary code gives two's complement
  generate
    if (SH > 0) begin : g_pad
      assign mid_word = {~sample_i[ADC_W-1], sample_i[ADC_W-2:0], {SH{1'b0}}};
      assign wide     = {diff, {SH{1'b0}}};
    end else begin : g_nopad
      assign mid_word = {~sample_i[ADC_W-1], sample_i[ADC_W-2:0]};
      assign wide     = diff;
    end
  endgenerate

  assign diff     = {1'b0, sample_i} - {1'b0, offset_i};
  assign top_bits = wide[WIDE_W-1:OUT_W-1];
  assign in_range = (&top_bits) || (~|top_bits);
  assign cal_word = in_range ? wide[OUT_W-1:0]
                             : (wide[WIDE_W-1] ? NEG_MAX : POS_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      q_o     <= '0;
    end else begin
      valid_o <= accept_i;
      if (accept_i) q_o <= (mode_i == CONV_CALIBRATED) ? cal_word : mid_word;
    end
  end

  generate
    if (SH > 0) begin : g_chk_pad
      p_mid_low_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accept_i && mode_i == CONV_MIDSCALE) |=> (q_o[SH-1:0] == '0));
    end
  endgenerate
  p_neg_sign_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && mode_i == CONV_CALIBRATED && sample_i < offset_i) |=> q_o[OUT_W-1]);
  p_pos_sign_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && mode_i == CONV_CALIBRATED && sample_i > offset_i)
      |=> (!q_o[OUT_W-1] && q_o != '0));
endmodule

// File: rtl/adc_gain_stage.sv
module adc_gain_stage
  import adc_qconv_pkg::*;
#(
  parameter int unsigned OUT_W  = OUT_W_DEF,
  parameter int unsigned GAIN_W = GAIN_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic              valid_i,
  input  logic [OUT_W-1:0]  q_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic              bypass_i,
  output logic              valid_o,
  output logic [OUT_W-1:0]  y_o
);
  localparam int unsigned PROD_W = OUT_W + GAIN_W;

  logic [GAIN_W-1:0]        gain_q;
  logic                     bypass_q;
  logic signed [PROD_W-1:0] prod;
  logic [OUT_W-1:0]         scaled;

  assign prod   = $signed(q_i) * $signed(gain_q);
  assign scaled = OUT_W'(prod >>> GAIN_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_q   <= '0;
      bypass_q <= 1'b1;
    end else if (!hold_i) begin
      gain_q   <= gain_i;
      bypass_q <= bypass_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      y_o     <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) y_o <= bypass_q ? q_i : scaled;
    end
  end

  p_cfg_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> ($stable(gain_q) && $stable(bypass_q)));
  p_neg_product_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !bypass_q && q_i != '0 && gain_q != '0 &&
     (q_i[OUT_W-1] ^ gain_q[GAIN_W-1])) |=> y_o[OUT_W-1]);
  p_pos_product_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !bypass_q && !q_i[OUT_W-1] && !gain_q[GAIN_W-1]) |=> !y_o[OUT_W-1]);
endmodule

// File: rtl/adc_qconv.sv
module adc_qconv
  import adc_qconv_pkg::*;
#(
  parameter int unsigned ADC_W    = ADC_W_DEF,
  parameter int unsigned OUT_W    = OUT_W_DEF,
  parameter int unsigned GAIN_W   = GAIN_W_DEF,
  parameter int unsigned CAL_LOG2 = CAL_LOG2_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_valid_i,
  input  logic [ADC_W-1:0]  sample_i,
  input  logic              cal_mode_i,
  input  logic              cal_start_i,
  input  logic              gain_bypass_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic              cal_done_o,
  output logic              result_valid_o,
  output logic [OUT_W-1:0]  result_o
);
  logic             cal_busy;
  logic [ADC_W-1:0] offset;
  logic             accept;
  logic             al_valid;
  logic [OUT_W-1:0] al_word;
  conv_mode_e       mode;

  assign mode   = conv_mode_e'(cal_mode_i);
  assign accept = sample_valid_i && !cal_busy;

  adc_offset_cal #(.ADC_W(ADC_W), .CAL_LOG2(CAL_LOG2)) u_cal (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cal_start_i   (cal_start_i),
    .sample_valid_i(sample_valid_i),
    .sample_i      (sample_i),
    .busy_o        (cal_busy),
    .offset_o      (offset),
    .cal_done_o    (cal_done_o)
  );

  adc_q15_align #(.ADC_W(ADC_W), .OUT_W(OUT_W)) u_align (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(accept),
    .mode_i  (mode),
    .sample_i(sample_i),
    .offset_i(offset),
    .valid_o (al_valid),
    .q_o     (al_word)
  );

  adc_gain_stage #(.OUT_W(OUT_W), .GAIN_W(GAIN_W)) u_gain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hold_i  (sample_valid_i || al_valid),
    .valid_i (al_valid),
    .q_i     (al_word),
    .gain_i  (gain_i),
    .bypass_i(gain_bypass_i),
    .valid_o (result_valid_o),
    .y_o     (result_o)
  );

  p_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o == $past(accept, 2));
  p_quiet_cal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cal_busy && $past(cal_busy)) |=> !result_valid_o);
  p_reset_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cal_busy) |-> !cal_done_o);
endmodule

// File: tb/adc_qconv_tb.sv
`timescale 1ns/1ps
module adc_qconv_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_valid = 1'b0;
  logic [11:0] sample = '0;
  logic        cal_mode = 1'b0;
  logic        cal_start = 1'b0;
  logic        bypass = 1'b1;
  logic [15:0] gain = '0;
  logic        cal_done;
  logic        rvalid;
  logic [15:0] result;

  int checks = 0;
  int fails  = 0;
  int exp_off = 2048;

  always #10 clk = ~clk;

  adc_qconv u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_valid_i(sample_valid), .sample_i(sample),
    .cal_mode_i(cal_mode), .cal_start_i(cal_start), .gain_bypass_i(bypass),
    .gain_i(gain), .cal_done_o(cal_done), .result_valid_o(rvalid), .result_o(result)
  );

  function automatic logic [15:0] exp_align(int s, int off, bit cal);
    int w;
    w = (s - (cal ? off : 2048)) * 16;
    if (w > 32767) w = 32767;
    if (w < -32768) w = -32768;
    return 16'(w);
  endfunction

  function automatic logic [15:0] exp_out(logic [15:0] q, logic [15:0] g, bit byp);
    longint p;
    if (byp) return q;
    p = longint'($signed(q)) * longint'($signed(g));
    return 16'(p >>> 16);
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic convert(string req, int s, bit cal, logic [15:0] g, bit byp);
    cal_mode = cal; gain = g; bypass = byp;
    @(negedge clk); @(negedge clk);
    sample_valid = 1'b1; sample = 12'(s);
    @(negedge clk);
    sample_valid = 1'b0;
    @(negedge clk);
    check({req, " R9 valid"}, 16'(rvalid), 16'd1);
    check(req, result, exp_out(exp_align(s, exp_off, cal), g, byp));
    @(negedge clk);
    check({req, " R9 single"}, 16'(rvalid), 16'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 valid", 16'(rvalid), 16'd0);
    check("R1 done", 16'(cal_done), 16'd0);
    check("R1 result", result, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    convert("R1 default offset", 4095, 1'b1, 16'h0000, 1'b1);
    check("R1 0x7FF0", result, 16'h7FF0);
  endtask

  task automatic t_midscale();
    convert("R2 code0", 0, 1'b0, 16'h0, 1'b1);
    check("R2 0x8000", result, 16'h8000);
    convert("R2 code2048", 2048, 1'b0, 16'h0, 1'b1);
    check("R2 zero", result, 16'h0000);
    convert("R2 code2047", 2047, 1'b0, 16'h0, 1'b1);
    convert("R2 code2049", 2049, 1'b0, 16'h0, 1'b1);
    convert("R2 code4095", 4095, 1'b0, 16'h0, 1'b1);
  endtask

  task automatic t_calibrate(int a, int b);
    int bad = 0;
    longint sum = 0;
    cal_start = 1'b1;
    @(negedge clk);
    cal_start = 1'b0;
    for (int i = 0; i < 4096; i++) begin
      sample_valid = 1'b1;
      sample = 12'((i % 2) ? b : a);
      sum += (i % 2) ? b : a;
      cal_start = (i == 100);
      @(negedge clk);
      if (rvalid) bad++;
      if (i < 4095 && cal_done) bad++;
    end
    cal_start = 1'b0;
    check("R4 no output or early done", 16'(bad), 16'd0);
    check("R3 done pulse", 16'(cal_done), 16'd1);
    sample_valid = 1'b0;
    @(negedge clk);
    check("R3 done one cycle", 16'(cal_done), 16'd0);
    exp_off = int'(sum >>> 12);
  endtask

  task automatic t_cal_modes();
    t_calibrate(2050, 2053);
    convert("R3 at offset", exp_off, 1'b1, 16'h0, 1'b1);
    check("R3 offset 2051", result, 16'h0000);
    convert("R5 full scale", 4095, 1'b1, 16'h0, 1'b1);
    convert("R6 neg clamp", 0, 1'b1, 16'h0, 1'b1);
    convert("R2 offset ignored", 2048, 1'b0, 16'h0, 1'b1);
    t_calibrate(100, 101);
    convert("R6 pos clamp", 4095, 1'b1, 16'h0, 1'b1);
    check("R6 0x7FFF", result, 16'h7FFF);
    convert("R5 below offset", 99, 1'b1, 16'h0, 1'b1);
    check("R5 -16", result, 16'hFFF0);
    t_calibrate(4000, 4001);
    convert("R6 deep neg", 0, 1'b1, 16'h0, 1'b1);
    check("R6 0x8000", result, 16'h8000);
  endtask

  task automatic t_gain();
    convert("R7 g28672 max", 4095, 1'b0, 16'd28672, 1'b0);
    convert("R7 g28672 min", 0, 1'b0, 16'd28672, 1'b0);
    convert("R7 g28672 mid", 3000, 1'b0, 16'd28672, 1'b0);
    convert("R7 neg gain", 4095, 1'b0, 16'hC000, 1'b0);
    convert("R7 neg times neg", 0, 1'b0, 16'h8000, 1'b0);
    convert("R8 bypass", 3000, 1'b0, 16'h1234, 1'b1);
  endtask

  task automatic t_gain_hold();
    int s[3] = '{4095, 1000, 2500};
    cal_mode = 1'b0; gain = 16'h4000; bypass = 1'b0;
    @(negedge clk); @(negedge clk);
    for (int n = 0; n < 5; n++) begin
      if (n >= 2) begin
        check("R9 burst valid", 16'(rvalid), 16'd1);
        check("R10 old gain in burst", result,
              exp_out(exp_align(s[n-2], exp_off, 1'b0), 16'h4000, 1'b0));
      end
      if (n < 3) begin
        sample_valid = 1'b1; sample = 12'(s[n]);
        if (n == 0) begin gain = 16'h2000; bypass = 1'b1; end
      end else sample_valid = 1'b0;
      @(negedge clk);
    end
    convert("R10 new cfg after idle", 1000, 1'b0, 16'h2000, 1'b1);
  endtask

  initial begin
    #(20ns * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_midscale();
    t_gain();
    t_cal_modes();
    t_gain_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule